// File: doc/BRIEF.md
# Virtual Address Segment Decoder

This block sorts every 32-bit virtual address into one of four address windows, using the three most significant address bits and the current privilege level. Two windows are translated by the page translation buffer: the low half of the space, shared by user and kernel code, and the top quarter, which is kernel-only and mapped per process. The remaining two kernel windows bypass translation and look onto the bottom 512 MB of physical memory. One is cached and one is uncached. For these two windows the block forms the physical address at once by clearing the top three address bits.

The block is purely combinational. It sits in front of the translation buffer and the cache. For each access it reports whether a translation lookup is needed, whether the access may be cached, and whether the address is illegal for the current privilege level. It also splits the address into a 20-bit page number and a 12-bit byte offset for the lookup. When an address is illegal, the mapped and cacheable outputs are held low so that no memory access starts.

Top module: `vaseg_decode`

## Requirements
- R1: An address with bit 31 = 0 gives segment code 0, mapped = 1, cacheable = 1 and address error = 0, in both user and kernel mode.
- R2: In kernel mode, an address with bits 31:29 = 100 gives segment code 1, mapped = 0 and cacheable = 1. The direct physical address equals the address with bits 31:29 cleared.
- R3: In kernel mode, an address with bits 31:29 = 101 gives segment code 2, mapped = 0 and cacheable = 0. The direct physical address equals the address with bits 31:29 cleared.
- R4: In kernel mode, an address with bits 31:30 = 11 gives segment code 3, mapped = 1 and cacheable = 1.
- R5: In user mode, an address with bit 31 = 1 sets address error = 1 and forces mapped = 0, cacheable = 0 and direct physical address = 0. The segment code still follows the address bits.
- R6: The direct physical address is 0 whenever the segment is a translated one (code 0 or 3).
- R7: The page number output always equals address bits 31:12, and the offset output always equals bits 11:0.
- R8: Address error is 0 whenever the mode is kernel or bit 31 is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| va_i | input | 32 | Virtual address |
| user_mode_i | input | 1 | 1 = user privilege, 0 = kernel |
| seg_o | output | 2 | Segment code: 0 user, 1 direct cached, 2 direct uncached, 3 kernel mapped |
| mapped_o | output | 1 | Access needs a translation lookup |
| cacheable_o | output | 1 | Access may use the cache |
| addr_err_o | output | 1 | Address is illegal at this privilege level |
| direct_pa_o | output | 32 | Physical address for the untranslated windows, else 0 |
| vpn_o | output | 20 | Virtual page number |
| page_ofs_o | output | 12 | Byte offset within the page |

## Verification
The block holds no state, so any fault in its decode shows on the outputs in the same evaluation as the address that triggers it. A wrong prefix decode at a window edge appears as a wrong segment code or a wrong flag. A fault in the address-error path appears as a mapped or cacheable flag raised on an illegal user access. Directed addresses at both ends of each window are mixed with seeded random addresses in both privilege modes. This exposes off-by-one bit selections in the prefix and in the cleared address bits.

// File: rtl/vaseg_pkg.sv
package vaseg_pkg;
   typedef enum logic [1:0] {
      SEG_USER      = 2'd0,
      SEG_DIRECT_C  = 2'd1,
      SEG_DIRECT_UC = 2'd2,
      SEG_KMAPPED   = 2'd3
   } seg_e;

   typedef struct packed {
      seg_e seg;
      logic mapped;
      logic cacheable;
      logic err;
      logic direct;
   } seg_attr_t;

   localparam int PREFIX_W = 3;
endpackage

// File: rtl/vaseg_classify.sv
module vaseg_classify
   import vaseg_pkg::*;
(
   input  logic [PREFIX_W-1:0] prefix_i,
   input  logic                user_mode_i,
   output seg_attr_t           attr_o
);
   seg_e seg;
   logic err;

   always_comb begin
      if (!prefix_i[PREFIX_W-1])      seg = SEG_USER;
      else if (prefix_i[PREFIX_W-2])  seg = SEG_KMAPPED;
      else if (prefix_i[PREFIX_W-3])  seg = SEG_DIRECT_UC;
      else                            seg = SEG_DIRECT_C;
   end

   assign err = user_mode_i & prefix_i[PREFIX_W-1];

   always_comb begin
      attr_o.seg       = seg;
      attr_o.err       = err;
      attr_o.mapped    = 1'b0;
      attr_o.cacheable = 1'b0;
      attr_o.direct    = 1'b0;
      if (!err) begin
         case (seg)
            SEG_USER, SEG_KMAPPED: begin
               attr_o.mapped    = 1'b1;
               attr_o.cacheable = 1'b1;
            end
            SEG_DIRECT_C: begin
               attr_o.cacheable = 1'b1;
               attr_o.direct    = 1'b1;
            end
            default: begin
               attr_o.direct    = 1'b1;
            end
         endcase
      end
   end
endmodule

// File: rtl/vaseg_direct.sv
module vaseg_direct #(
   parameter int ADDR_W = 32,
   parameter int KEEP_W = 29
) (
   input  logic [ADDR_W-1:0] va_i,
   input  logic              en_i,
   output logic [ADDR_W-1:0] pa_o
);
   for (genvar b = 0; b < ADDR_W; b++) begin : g_bit
      if (b < KEEP_W) begin : g_keep
         assign pa_o[b] = en_i & va_i[b];
      end else begin : g_clear
         assign pa_o[b] = 1'b0;
      end
   end
endmodule

// File: rtl/vaseg_split.sv
module vaseg_split #(
   parameter int ADDR_W = 32,
   parameter int OFS_W  = 12,
   localparam int VPN_W = ADDR_W - OFS_W
) (
   input  logic [ADDR_W-1:0] va_i,
   output logic [VPN_W-1:0]  vpn_o,
   output logic [OFS_W-1:0]  ofs_o
);
   assign vpn_o = va_i[ADDR_W-1:OFS_W];
   assign ofs_o = va_i[OFS_W-1:0];
endmodule

// File: rtl/vaseg_decode.sv
module vaseg_decode
   import vaseg_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int OFS_W  = 12,
   localparam int VPN_W  = ADDR_W - OFS_W,
   localparam int KEEP_W = ADDR_W - PREFIX_W
) (
   input  logic [ADDR_W-1:0] va_i,
   input  logic              user_mode_i,
   output logic [1:0]        seg_o,
   output logic              mapped_o,
   output logic              cacheable_o,
   output logic              addr_err_o,
   output logic [ADDR_W-1:0] direct_pa_o,
   output logic [VPN_W-1:0]  vpn_o,
   output logic [OFS_W-1:0]  page_ofs_o
);
   if (ADDR_W < OFS_W + PREFIX_W || OFS_W < 1) begin : g_bad_cfg
      $error("vaseg_decode: ADDR_W must cover OFS_W plus the prefix bits");
   end

   seg_attr_t attr;

   vaseg_classify u_cls (
      .prefix_i    (va_i[ADDR_W-1 -: PREFIX_W]),
      .user_mode_i (user_mode_i),
      .attr_o      (attr)
   );

   vaseg_direct #(.ADDR_W(ADDR_W), .KEEP_W(KEEP_W)) u_dir (
      .va_i (va_i),
      .en_i (attr.direct),
      .pa_o (direct_pa_o)
   );

   vaseg_split #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_split (
      .va_i  (va_i),
      .vpn_o (vpn_o),
      .ofs_o (page_ofs_o)
   );

   assign seg_o       = attr.seg;
   assign mapped_o    = attr.mapped;
   assign cacheable_o = attr.cacheable;
   assign addr_err_o  = attr.err;
endmodule

// File: rtl/vaseg_chk.sv
module vaseg_chk #(
   parameter int ADDR_W = 32,
   parameter int OFS_W  = 12
) (
   input logic [ADDR_W-1:0]       va_i,
   input logic                    user_mode_i,
   input logic [1:0]              seg_o,
   input logic                    mapped_o,
   input logic                    cacheable_o,
   input logic                    addr_err_o,
   input logic [ADDR_W-1:0]       direct_pa_o,
   input logic [ADDR_W-OFS_W-1:0] vpn_o,
   input logic [OFS_W-1:0]        page_ofs_o
);
   always_comb begin
      if (!$isunknown({va_i, user_mode_i})) begin
         // R1
         user_seg_chk: assert (va_i[ADDR_W-1] || (seg_o == 2'd0 && mapped_o && cacheable_o));
         // R5
         err_quiet_chk: assert (!addr_err_o || (!mapped_o && !cacheable_o && direct_pa_o == '0));
         // R8
         kernel_no_err_chk: assert (user_mode_i || !addr_err_o);
         // R6
         mapped_no_pa_chk: assert (!mapped_o || direct_pa_o == '0);
         // R7
         split_chk: assert ({vpn_o, page_ofs_o} == va_i);
         // R3
         uncached_chk: assert (seg_o != 2'd2 || !cacheable_o);
         // R4
         kmapped_chk: assert (seg_o != 2'd3 || addr_err_o || (mapped_o && cacheable_o));
      end
   end
endmodule

bind vaseg_decode vaseg_chk #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_chk (.*);

// File: tb/tb_vaseg_decode.sv
module tb_vaseg_decode;
   logic clk = 1'b0;
   logic rst = 1'b1;
   always #5 clk = ~clk;

   logic [31:0] va;
   logic        um;
   logic [1:0]  seg;
   logic        mapped, cacheable, err;
   logic [31:0] pa;
   logic [19:0] vpn;
   logic [11:0] ofs;

   int vectors = 0;
   int fails   = 0;

   vaseg_decode dut (
      .va_i(va), .user_mode_i(um), .seg_o(seg), .mapped_o(mapped),
      .cacheable_o(cacheable), .addr_err_o(err), .direct_pa_o(pa),
      .vpn_o(vpn), .page_ofs_o(ofs)
   );

   function automatic logic [1:0] exp_seg(input logic [31:0] a);
      if (!a[31]) return 2'd0;
      if (a[30])  return 2'd3;
      if (a[29])  return 2'd2;
      return 2'd1;
   endfunction

   function automatic string seg_tag(input logic [31:0] a, input logic u);
      if (u && a[31]) return "R5";
      case (exp_seg(a))
         2'd0: return "R1";
         2'd1: return "R2";
         2'd2: return "R3";
         default: return "R4";
      endcase
   endfunction

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s va=%h um=%0b actual=%h expected=%h",
                  req, what, va, um, act, exp);
      end
   endtask

   task automatic apply(input logic [31:0] a, input logic u);
      logic [1:0] s;
      logic       e, m, c;
      logic [31:0] p;
      string      t;
      @(posedge clk);
      #1;
      va = a;
      um = u;
      @(negedge clk);
      s = exp_seg(a);
      e = u & a[31];
      m = !e && (s == 2'd0 || s == 2'd3);
      c = !e && (s != 2'd2);
      p = (!e && (s == 2'd1 || s == 2'd2)) ? {3'b000, a[28:0]} : 32'd0;
      t = seg_tag(a, u);
      vectors++;
      chk(t, "seg", {30'd0, seg}, {30'd0, s});
      chk(t, "mapped", {31'd0, mapped}, {31'd0, m});
      chk(t, "cacheable", {31'd0, cacheable}, {31'd0, c});
      chk(e ? "R5" : "R8", "addr_err", {31'd0, err}, {31'd0, e});
      chk(m ? "R6" : t, "direct_pa", pa, p);
      chk("R7", "vpn", {12'd0, vpn}, {12'd0, a[31:12]});
      chk("R7", "offset", {20'd0, ofs}, {20'd0, a[11:0]});
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      va = 32'd0;
      um = 1'b0;
      repeat (3) @(posedge clk);
      rst = 1'b0;
      // reset-time state: address 0, kernel mode (R1)
      apply(32'h0000_0000, 1'b0);
      // window edges in both modes (R1..R6, R8)
      for (int m = 0; m < 2; m++) begin
         apply(32'h0000_0000, m[0]);
         apply(32'h7FFF_FFFF, m[0]);
         apply(32'h8000_0000, m[0]);
         apply(32'h9FFF_FFFF, m[0]);
         apply(32'hA000_0000, m[0]);
         apply(32'hBFFF_FFFF, m[0]);
         apply(32'hC000_0000, m[0]);
         apply(32'hFFFF_FFFF, m[0]);
         apply(32'h8000_1ABC, m[0]);
         apply(32'hA123_4567, m[0]);
      end
      void'($urandom(32'd20250));
      for (int i = 0; i < 3000; i++) begin
         apply($urandom(), 1'($urandom() & 1));
      end
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end
endmodule